// File: doc/BRIEF.md
# Doorbell Signalling Unit

This block holds a set of doorbells, one per receiving master. A sending master rings a doorbell by writing 1 to that doorbell's trigger register. Each write carries the sender's master ID on a sideband input. The receiver decides which senders may reach it through a per-doorbell enable bitmap that has one bit per master ID. Every ring is logged in a raw register, whatever the enable bitmap says. Only permitted rings are logged in the pending register, at the bit given by the sender's ID.

Each doorbell raises its own interrupt line while any of its pending bits is set. The receiver services an interrupt in two steps: it reads the pending register, then writes the same value back, which clears exactly the bits it has handled. The block has two independent write ports, so that a sender and a receiver can reach the same doorbell in the same cycle. It also has one combinational read port. An address is made of a doorbell index in the upper bits and an 8-bit offset within that doorbell's window.

Top module: `db_unit`

## Requirements
- R1: A write to offset 0x0 (trigger) of doorbell d with data bit 0 equal to 1, by master m, sets bit m of d's raw register (offset 0x8) on the next clock edge. This happens whatever d's enable bits are.
- R2: The same ring sets bit m of d's pending register (offset 0xC) only if bit m of d's enable register was 1 before that edge.
- R3: A trigger write with data bit 0 equal to 0 changes no register. A read of offset 0x0 always returns 0.
- R4: The enable register (offset 0x4) holds the low NUM_MASTERS bits written to it, and its upper bits read 0. It changes only when it is written.
- R5: Writing a value to the pending register clears the pending bits that are 1 in the value and leaves every other pending bit unchanged.
- R6: irq_o[d] is 1 exactly while d's pending register is non-zero. It falls only in the cycle after a write to d's pending register.
- R7: When a ring and a pending clear of the same bit happen in the same cycle, the bit ends up set.
- R8: The raw register is write-1-to-clear in the same way as the pending register.
- R9: When both write ports write the same doorbell's enable register in one cycle, the value from port 1 is kept.
- R10: The address is {index, offset[7:0]}. Offsets other than 0x0, 0x4, 0x8 and 0xC read as 0, and writes to them are ignored.
- R11: A write changes only the doorbell that its address selects. The other doorbells' registers and interrupt lines stay as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | NUM_WP | Write strobe for each write port |
| wr_addr_i | input | NUM_WP x ADDR_W | Write address for each port: {index, offset} |
| wr_data_i | input | NUM_WP x DW | Write data for each port |
| wr_mid_i | input | NUM_WP x MID_W | Master ID of the writer on each port |
| rd_addr_i | input | ADDR_W | Read address |
| rd_data_o | output | DW | Combinational read data |
| irq_o | output | NUM_DB | Interrupt line for each doorbell |

## Verification
A wrong enable bit shows up on the next ring from that master. The pending bit and the interrupt line then take the wrong value one edge after the trigger write, and reading the raw register tells the two errors apart: a missed ring leaves raw clear, while a wrongly gated ring leaves raw set. A clear that removes too much, or too little, shows up as soon as the pending register is read back after the write-back. It also shows up on the interrupt line, which either drops early or stays high. A lost event when a ring and a clear collide shows up as a missing pending bit in the cycle that follows them.

// File: rtl/db_unit_pkg.sv
package db_unit_pkg;
  typedef enum logic [1:0] {
    REG_TRIG = 2'd0,
    REG_EN   = 2'd1,
    REG_RAW  = 2'd2,
    REG_PEND = 2'd3
  } db_reg_e;

  localparam int unsigned WIN_OFF_W = 8;

  // one-hot register select for a window offset; zero for unmapped offsets
  function automatic logic [3:0] off_to_sel(input logic [WIN_OFF_W-1:0] off);
    logic [3:0] s;
    s = '0;
    if (off[1:0] == 2'b00 && off[7:4] == 4'h0) s[off[3:2]] = 1'b1;
    return s;
  endfunction
endpackage

// File: rtl/db_decode.sv
module db_decode
  import db_unit_pkg::*;
#(
  parameter int unsigned NUM_DB = 8,
  parameter int unsigned IDX_W  = 3,
  parameter int unsigned ADDR_W = IDX_W + WIN_OFF_W
) (
  input  logic                    en_i,
  input  logic [ADDR_W-1:0]       addr_i,
  output logic [NUM_DB-1:0][3:0]  sel_o
);
  logic [IDX_W-1:0] idx;

  assign idx = addr_i[ADDR_W-1:WIN_OFF_W];

  always_comb begin
    sel_o = '0;
    if (en_i && int'(idx) < NUM_DB) sel_o[idx] = off_to_sel(addr_i[WIN_OFF_W-1:0]);
  end
endmodule

// File: rtl/db_cell.sv
module db_cell
  import db_unit_pkg::*;
#(
  parameter int unsigned NUM_WP = 2,
  parameter int unsigned NM     = 8,
  parameter int unsigned MID_W  = 3,
  parameter int unsigned DW     = 32
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NUM_WP-1:0][3:0]       sel_i,
  input  logic [NUM_WP-1:0][DW-1:0]    wdata_i,
  input  logic [NUM_WP-1:0][MID_W-1:0] mid_i,
  output logic [NM-1:0]                en_o,
  output logic [NM-1:0]                raw_o,
  output logic [NM-1:0]                pend_o,
  output logic                         irq_o
);
  logic [NM-1:0] ring, pclr, rclr, en_d;

  always_comb begin
    ring = '0;
    pclr = '0;
    rclr = '0;
    en_d = en_o;
    for (int p = 0; p < NUM_WP; p++) begin
      if (sel_i[p][REG_TRIG] && wdata_i[p][0] && int'(mid_i[p]) < NM) ring[mid_i[p]] = 1'b1;
      if (sel_i[p][REG_EN])   en_d = wdata_i[p][NM-1:0];  // higher port wins
      if (sel_i[p][REG_RAW])  rclr |= wdata_i[p][NM-1:0];
      if (sel_i[p][REG_PEND]) pclr |= wdata_i[p][NM-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o   <= '0;
      raw_o  <= '0;
      pend_o <= '0;
    end else begin
      en_o   <= en_d;
      raw_o  <= (raw_o & ~rclr) | ring;
      // ring applied after clear: a same-cycle ring survives; gate uses pre-write enable
      pend_o <= (pend_o & ~pclr) | (ring & en_o);
    end
  end

  assign irq_o = |pend_o;
endmodule

// File: rtl/db_rd_mux.sv
module db_rd_mux
  import db_unit_pkg::*;
#(
  parameter int unsigned NUM_DB = 8,
  parameter int unsigned NM     = 8,
  parameter int unsigned IDX_W  = 3,
  parameter int unsigned DW     = 32,
  parameter int unsigned ADDR_W = IDX_W + WIN_OFF_W
) (
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [NUM_DB-1:0][NM-1:0]  en_i,
  input  logic [NUM_DB-1:0][NM-1:0]  raw_i,
  input  logic [NUM_DB-1:0][NM-1:0]  pend_i,
  output logic [DW-1:0]              rdata_o
);
  logic [IDX_W-1:0] idx;
  logic [3:0]       sel;

  assign idx = addr_i[ADDR_W-1:WIN_OFF_W];
  assign sel = off_to_sel(addr_i[WIN_OFF_W-1:0]);

  always_comb begin
    rdata_o = '0;
    if (int'(idx) < NUM_DB) begin
      if (sel[REG_EN])   rdata_o[NM-1:0] = en_i[idx];
      if (sel[REG_RAW])  rdata_o[NM-1:0] = raw_i[idx];
      if (sel[REG_PEND]) rdata_o[NM-1:0] = pend_i[idx];
    end
  end
endmodule

// File: rtl/db_unit.sv
module db_unit
  import db_unit_pkg::*;
#(
  parameter int unsigned NUM_DB      = 8,
  parameter int unsigned NUM_MASTERS = 8,
  parameter int unsigned NUM_WP      = 2,
  parameter int unsigned DW          = 32,
  localparam int unsigned IDX_W  = (NUM_DB > 1) ? $clog2(NUM_DB) : 1,
  localparam int unsigned MID_W  = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1,
  localparam int unsigned ADDR_W = IDX_W + WIN_OFF_W
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NUM_WP-1:0]            wr_en_i,
  input  logic [NUM_WP-1:0][ADDR_W-1:0] wr_addr_i,
  input  logic [NUM_WP-1:0][DW-1:0]    wr_data_i,
  input  logic [NUM_WP-1:0][MID_W-1:0] wr_mid_i,
  input  logic [ADDR_W-1:0]            rd_addr_i,
  output logic [DW-1:0]                rd_data_o,
  output logic [NUM_DB-1:0]            irq_o
);
  logic [NUM_WP-1:0][NUM_DB-1:0][3:0] sel_pd;
  logic [NUM_DB-1:0][NUM_WP-1:0][3:0] sel_dp;
  logic [NUM_DB-1:0][NUM_MASTERS-1:0] en_all, raw_all, pend_all;

  for (genvar p = 0; p < NUM_WP; p++) begin : g_port
    db_decode #(.NUM_DB(NUM_DB), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) i_dec (
      .en_i   (wr_en_i[p]),
      .addr_i (wr_addr_i[p]),
      .sel_o  (sel_pd[p])
    );
    for (genvar d = 0; d < NUM_DB; d++) begin : g_tr
      assign sel_dp[d][p] = sel_pd[p][d];
    end
  end

  for (genvar d = 0; d < NUM_DB; d++) begin : g_db
    db_cell #(.NUM_WP(NUM_WP), .NM(NUM_MASTERS), .MID_W(MID_W), .DW(DW)) i_cell (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .sel_i   (sel_dp[d]),
      .wdata_i (wr_data_i),
      .mid_i   (wr_mid_i),
      .en_o    (en_all[d]),
      .raw_o   (raw_all[d]),
      .pend_o  (pend_all[d]),
      .irq_o   (irq_o[d])
    );
  end

  db_rd_mux #(.NUM_DB(NUM_DB), .NM(NUM_MASTERS), .IDX_W(IDX_W), .DW(DW), .ADDR_W(ADDR_W)) i_rd (
    .addr_i  (rd_addr_i),
    .en_i    (en_all),
    .raw_i   (raw_all),
    .pend_i  (pend_all),
    .rdata_o (rd_data_o)
  );
endmodule

// File: rtl/db_unit_chk.sv
module db_unit_chk #(
  parameter int unsigned NUM_DB = 8,
  parameter int unsigned NM     = 8,
  parameter int unsigned NUM_WP = 2,
  parameter int unsigned DW     = 32,
  parameter int unsigned IDX_W  = 3,
  parameter int unsigned MID_W  = 3,
  parameter int unsigned ADDR_W = 11
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic [NUM_WP-1:0]            wr_en_i,
  input logic [NUM_WP-1:0][ADDR_W-1:0] wr_addr_i,
  input logic [NUM_WP-1:0][DW-1:0]    wr_data_i,
  input logic [NUM_WP-1:0][MID_W-1:0] wr_mid_i,
  input logic [ADDR_W-1:0]            rd_addr_i,
  input logic [DW-1:0]                rd_data_o,
  input logic [NUM_DB-1:0]            irq_o,
  input logic [NUM_DB-1:0][NM-1:0]    en_all,
  input logic [NUM_DB-1:0][NM-1:0]    pend_all
);
  logic [NUM_DB-1:0] en_wr, pclr_wr, trig0;

  always_comb begin
    en_wr = '0;
    pclr_wr = '0;
    trig0 = '0;
    for (int d = 0; d < NUM_DB; d++) begin
      for (int p = 0; p < NUM_WP; p++) begin
        if (wr_en_i[p] && int'(wr_addr_i[p][ADDR_W-1:8]) == d) begin
          if (wr_addr_i[p][7:0] == 8'h04) en_wr[d] = 1'b1;
          if (wr_addr_i[p][7:0] == 8'h0C) pclr_wr[d] = 1'b1;
        end
      end
      trig0[d] = wr_en_i[0] && int'(wr_addr_i[0][ADDR_W-1:8]) == d &&
                 wr_addr_i[0][7:0] == 8'h00 && wr_data_i[0][0];
    end
  end

  // R3
  trig_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_addr_i[7:0] == 8'h00 |-> rd_data_o == '0);

  for (genvar d = 0; d < NUM_DB; d++) begin : g_d
    // R4
    en_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_wr[d] |=> $stable(en_all[d]));
    // R6
    irq_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(irq_o[d]) |-> $past(pclr_wr[d]));
    // R7
    ring_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (trig0[d] && en_all[d][wr_mid_i[0]]) |=> pend_all[d][$past(wr_mid_i[0])]);
    for (genvar m = 0; m < NM; m++) begin : g_m
      // R2
      pend_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(pend_all[d][m]) |-> $past(en_all[d][m]));
    end
  end
endmodule

bind db_unit db_unit_chk #(
  .NUM_DB(NUM_DB), .NM(NUM_MASTERS), .NUM_WP(NUM_WP), .DW(DW),
  .IDX_W(IDX_W), .MID_W(MID_W), .ADDR_W(ADDR_W)
) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .wr_data_i (wr_data_i),
  .wr_mid_i  (wr_mid_i),
  .rd_addr_i (rd_addr_i),
  .rd_data_o (rd_data_o),
  .irq_o     (irq_o),
  .en_all    (en_all),
  .pend_all  (pend_all)
);

// File: tb/test_db_unit.sv
module test_db_unit;
  localparam int NDB = 8;
  localparam int AW  = 11;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [1:0]      wr_en = '0;
  logic [1:0][AW-1:0] wr_addr = '0;
  logic [1:0][31:0]   wr_data = '0;
  logic [1:0][2:0]    wr_mid = '0;
  logic [AW-1:0]   rd_addr = '0;
  logic [31:0]     rd_data;
  logic [NDB-1:0]  irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  bit mon_v = 1'b0;
  logic [32:0] exp_q[$];
  string       req_q[$];

  logic [7:0] m_en[NDB];
  logic [7:0] m_raw[NDB];
  logic [7:0] m_pend[NDB];

  always #5 clk = ~clk;

  db_unit i_db_unit (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .wr_mid_i(wr_mid), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .irq_o(irq)
  );

  function automatic logic [AW-1:0] ad(input int db, input logic [7:0] off);
    return {db[2:0], off};
  endfunction

  function automatic logic [31:0] irq_model();
    logic [31:0] v = '0;
    for (int d = 0; d < NDB; d++) v[d] = |m_pend[d];
    return v;
  endfunction

  // driver: one clock of writes on both ports, with model update
  task automatic cyc(input logic v0, input logic [AW-1:0] a0, input logic [31:0] d0, input logic [2:0] i0,
                     input logic v1, input logic [AW-1:0] a1, input logic [31:0] d1, input logic [2:0] i1);
    logic [1:0] v;
    logic [1:0][AW-1:0] a;
    logic [1:0][31:0] dt;
    logic [1:0][2:0] id;
    v = {v1, v0}; a = {a1, a0}; dt = {d1, d0}; id = {i1, i0};
    @(negedge clk);
    wr_en = v; wr_addr = a; wr_data = dt; wr_mid = id;
    for (int d = 0; d < NDB; d++) begin
      logic [7:0] ring, pclr, rclr, en_n;
      ring = '0; pclr = '0; rclr = '0; en_n = m_en[d];
      for (int p = 0; p < 2; p++) begin
        if (v[p] && int'(a[p][AW-1:8]) == d) begin
          case (a[p][7:0])
            8'h00: if (dt[p][0]) ring[id[p]] = 1'b1;
            8'h04: en_n = dt[p][7:0];
            8'h08: rclr |= dt[p][7:0];
            8'h0C: pclr |= dt[p][7:0];
            default: ;
          endcase
        end
      end
      m_raw[d]  = (m_raw[d] & ~rclr) | ring;
      m_pend[d] = (m_pend[d] & ~pclr) | (ring & m_en[d]);
      m_en[d]   = en_n;
    end
    @(negedge clk);
    wr_en = '0;
  endtask

  task automatic wr(input int db, input logic [7:0] off, input logic [31:0] d, input logic [2:0] id);
    cyc(1'b1, ad(db, off), d, id, 1'b0, '0, '0, '0);
  endtask

  task automatic chk_rd(input int db, input logic [7:0] off, input string req);
    logic [31:0] e;
    @(negedge clk);
    rd_addr = ad(db, off);
    case (off)
      8'h04: e = {24'h0, m_en[db]};
      8'h08: e = {24'h0, m_raw[db]};
      8'h0C: e = {24'h0, m_pend[db]};
      default: e = '0;
    endcase
    exp_q.push_back({1'b0, e});
    req_q.push_back(req);
    mon_v = 1'b1;
    @(negedge clk);
    mon_v = 1'b0;
  endtask

  task automatic chk_irq(input string req);
    @(negedge clk);
    exp_q.push_back({1'b1, irq_model()});
    req_q.push_back(req);
    mon_v = 1'b1;
    @(negedge clk);
    mon_v = 1'b0;
  endtask

  // monitor: compares away from the active edge
  always @(negedge clk) begin
    #3;
    if (mon_v && exp_q.size() > 0) begin
      logic [32:0] it;
      logic [31:0] act;
      string r;
      it = exp_q.pop_front();
      r = req_q.pop_front();
      act = it[32] ? {24'h0, irq} : rd_data;
      checks++;
      if (act !== it[31:0]) begin
        fails++;
        $display("FAIL %s actual %h expected %h", r, act, it[31:0]);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int d = 0; d < NDB; d++) begin m_en[d] = '0; m_raw[d] = '0; m_pend[d] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state
    chk_rd(0, 8'h04, "R4 reset enable");
    chk_rd(0, 8'h0C, "R5 reset pending");
    chk_irq("R6 reset irq");
    // enable write and readback, upper bits dropped
    wr(3, 8'h04, 32'h0000_000A, 3'd3);
    chk_rd(3, 8'h04, "R4 enable readback");
    wr(2, 8'h04, 32'hFFFF_FFFF, 3'd2);
    chk_rd(2, 8'h04, "R4 enable upper bits zero");
    // enabled ring from master 1
    wr(3, 8'h00, 32'h1, 3'd1);
    chk_rd(3, 8'h08, "R1 raw after ring");
    chk_rd(3, 8'h0C, "R2 pending after enabled ring");
    chk_irq("R6 irq on pending R11 other doorbells quiet");
    // disabled ring from master 2
    wr(3, 8'h00, 32'h1, 3'd2);
    chk_rd(3, 8'h08, "R1 raw records disabled ring");
    chk_rd(3, 8'h0C, "R2 pending unchanged by disabled ring");
    // trigger with bit0 = 0, and trigger readback
    wr(3, 8'h00, 32'hFFFF_FFFE, 3'd3);
    chk_rd(3, 8'h0C, "R3 zero trigger no pending");
    chk_rd(3, 8'h08, "R3 zero trigger no raw");
    chk_rd(3, 8'h00, "R3 trigger reads zero");
    // second enabled ring, then partial write-back clear
    wr(3, 8'h00, 32'h1, 3'd3);
    chk_rd(3, 8'h0C, "R2 two pending bits");
    wr(3, 8'h0C, 32'h0000_0002, 3'd3);
    chk_rd(3, 8'h0C, "R5 partial clear");
    chk_irq("R6 irq held with bit left");
    wr(3, 8'h0C, 32'h0000_0008, 3'd3);
    chk_rd(3, 8'h0C, "R5 full clear");
    chk_irq("R6 irq dropped");
    // raw write-1-to-clear
    wr(3, 8'h08, 32'h0000_0004, 3'd3);
    chk_rd(3, 8'h08, "R8 raw clear");
    // ring on port 0 vs clear on port 1, same bit
    wr(3, 8'h00, 32'h1, 3'd1);
    cyc(1'b1, ad(3, 8'h00), 32'h1, 3'd1, 1'b1, ad(3, 8'h0C), 32'h0000_0002, 3'd3);
    chk_rd(3, 8'h0C, "R7 ring wins over clear");
    chk_irq("R7 irq stays high");
    // concurrent enable writes
    cyc(1'b1, ad(5, 8'h04), 32'h11, 3'd0, 1'b1, ad(5, 8'h04), 32'h22, 3'd1);
    chk_rd(5, 8'h04, "R9 port 1 enable wins");
    // top doorbell index, top master ID
    wr(7, 8'h04, 32'h80, 3'd7);
    wr(7, 8'h00, 32'h1, 3'd7);
    chk_rd(7, 8'h0C, "R11 top doorbell pending");
    chk_irq("R11 irq vector");
    // unmapped offset ignored
    wr(3, 8'h10, 32'hFF, 3'd1);
    wr(3, 8'h06, 32'hFF, 3'd1);
    chk_rd(3, 8'h10, "R10 unmapped reads zero");
    chk_rd(3, 8'h04, "R10 enable untouched");
    chk_rd(3, 8'h0C, "R10 pending untouched");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule